// File: doc/BRIEF.md
# Bank Refresh Command Tracker

This block sits on the memory side of a row-command path. Each cycle it takes one decoded row command: a normal activate that carries its own row, a precharge, a refresh activate, a refresh activate that also advances the refresh row counter, or a refresh precharge. Every command names one bank. The block keeps an open or closed flag for each bank and the row that bank last sensed. It also runs per-bank timers against the programmable row-active time (tRAS) and precharge time (tRP). Because every activate needs a precharge between it and the next one, the row-cycle time tRC = tRAS + tRP is met whenever both of those gaps are met.

Refresh activates take their row from an internal refresh row counter and never from the command. Only the incrementing refresh activate moves that counter forward, and it does so after the current value has been used. A controller can therefore refresh the same row in every bank and then step to the next row. The counter is split into three equal slices (low, middle, high). Each slice can be read and written through a small select/data port.

A command that breaks a state or timing rule is dropped. It leaves every piece of state as it was, and the block raises a one-cycle error flag in the cycle after the command.

Top module: `bank_refresh_tracker`

## Requirements
- R1: After reset all banks are closed, every sensed row reads 0, the refresh counter is 0 and both error flags are low.
- R2: The command code on cmd_op is 0 none, 1 activate, 2 precharge, 3 refresh activate, 4 refresh activate with increment, 5 refresh precharge; 6 and 7 act as none. An accepted activate (code 1) opens bank cmd_bank, and from the next cycle bank_row_o[b*12 +: 12] shows cmd_row.
- R3: An accepted refresh activate (code 3) opens its bank with the current counter value as its row and leaves the counter unchanged.
- R4: An accepted refresh activate with increment (code 4) opens its bank with the current counter value, then adds one to the counter, wrapping from 0xFFF to 0.
- R5: An accepted precharge (code 2) or refresh precharge (code 5) closes an open bank and leaves its sensed row value untouched.
- R6: Any activate (codes 1, 3, 4) to a bank that is already open is dropped: the row does not change, the counter does not advance, and err_state_o is high for the next cycle.
- R7: A precharge issued fewer than cfg_tras cycles after the activate that opened its bank is dropped, and err_timing_o is high for the next cycle; a precharge at exactly cfg_tras cycles is accepted.
- R8: An activate issued fewer than cfg_trp cycles after the precharge that closed its bank is dropped, and err_timing_o is high for the next cycle; at exactly cfg_trp cycles it is accepted.
- R9: Each bank keeps its own timers: an activate to another bank does not restart the tRAS window of a bank that is already open.
- R10: ctr_sel selects slice 0 = bits [3:0], 1 = [7:4], 2 = [11:8]; ctr_rdata shows the selected slice at once (0 for select 3). A write with ctr_wr_en replaces only that slice from the next cycle. A write with select 3 is ignored.
- R11: A slice write in the same cycle as an accepted code-4 command wins: the increment is lost, and the bank still opens with the counter value from before the write.
- R12: A precharge to a bank that is already closed has no effect: no error flag, and the bank's tRP window is not restarted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_op | input | 3 | Row command code |
| cmd_bank | input | 3 | Bank addressed by the command |
| cmd_row | input | 12 | Row for a normal activate |
| cfg_tras | input | 8 | Minimum cycles from activate to precharge |
| cfg_trp | input | 8 | Minimum cycles from precharge to activate |
| ctr_wr_en | input | 1 | Refresh counter slice write strobe |
| ctr_sel | input | 2 | Counter slice select for read and write |
| ctr_wdata | input | 4 | Slice write data |
| ctr_rdata | output | 4 | Selected slice read data |
| bank_open_o | output | 8 | Open flag per bank |
| bank_row_o | output | 96 | Sensed row per bank, 12 bits each, bank 0 lowest |
| err_state_o | output | 1 | An activate hit an open bank in the previous cycle |
| err_timing_o | output | 1 | A command broke tRAS or tRP in the previous cycle |

## Verification
The hardest cases to reach are the one-cycle edges of the timing windows for each pair of tRAS and tRP values. The bench sweeps tRAS from 1 to 5 and tRP from 1 to 4. For each pair it puts one precharge exactly one cycle early and the next precharge exactly on time, then does the same for the following activate. Expected results come from cycle arithmetic alone. A second hard case is a counter write landing in the same cycle as an incrementing refresh; the bench drives both together and checks the row that was sensed and the counter slices that result.

// File: rtl/rbt_pkg.sv
package rbt_pkg;

   typedef enum logic [2:0] {
      OP_NONE  = 3'd0,
      OP_ACT   = 3'd1,
      OP_PRE   = 3'd2,
      OP_RACT  = 3'd3,
      OP_RACTI = 3'd4,
      OP_RPRE  = 3'd5
   } row_op_e;

   function automatic logic op_is_act(input logic [2:0] op);
      return (op == OP_ACT) || (op == OP_RACT) || (op == OP_RACTI);
   endfunction

   function automatic logic op_is_pre(input logic [2:0] op);
      return (op == OP_PRE) || (op == OP_RPRE);
   endfunction

endpackage

// File: rtl/rbt_cmd_decode.sv
module rbt_cmd_decode
   import rbt_pkg::*;
#(
   parameter int NBANK = 8,
   parameter int ROW_W = 12,
   localparam int BANK_W = $clog2(NBANK)
) (
   input  logic [2:0]        op_i,
   input  logic [BANK_W-1:0] bank_i,
   input  logic [ROW_W-1:0]  pkt_row_i,
   input  logic [ROW_W-1:0]  ref_row_i,
   output logic [NBANK-1:0]  act_vec_o,
   output logic [NBANK-1:0]  pre_vec_o,
   output logic [ROW_W-1:0]  act_row_o,
   output logic              inc_req_o
);

   logic is_act, is_pre;

   assign is_act    = op_is_act(op_i);
   assign is_pre    = op_is_pre(op_i);
   assign act_row_o = (op_i == OP_ACT) ? pkt_row_i : ref_row_i;
   assign inc_req_o = (op_i == OP_RACTI);

   for (genvar b = 0; b < NBANK; b++) begin : g_sel
      assign act_vec_o[b] = is_act && (bank_i == BANK_W'(b));
      assign pre_vec_o[b] = is_pre && (bank_i == BANK_W'(b));
   end

endmodule

// File: rtl/rbt_bank_slot.sv
module rbt_bank_slot #(
   parameter int ROW_W = 12,
   parameter int TIM_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_act_i,
   input  logic             sel_pre_i,
   input  logic [ROW_W-1:0] act_row_i,
   input  logic [TIM_W-1:0] tras_i,
   input  logic [TIM_W-1:0] trp_i,
   output logic             open_o,
   output logic [ROW_W-1:0] row_o,
   output logic             viol_state_o,
   output logic             viol_time_o,
   output logic             act_ok_o
);

   logic             open_q;
   logic [ROW_W-1:0] row_q;
   logic [TIM_W-1:0] ras_q, rp_q;
   logic [TIM_W-1:0] ras_ld, rp_ld;
   logic             pre_ok;

   assign ras_ld = (tras_i == '0) ? '0 : tras_i - 1'b1;
   assign rp_ld  = (trp_i  == '0) ? '0 : trp_i  - 1'b1;

   assign viol_state_o = sel_act_i && open_q;
   assign viol_time_o  = (sel_act_i && (rp_q != '0)) ||
                         (sel_pre_i && open_q && (ras_q != '0));
   assign act_ok_o     = sel_act_i && !open_q && (rp_q == '0);
   assign pre_ok       = sel_pre_i && open_q && (ras_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         row_q  <= '0;
         ras_q  <= '0;
         rp_q   <= '0;
      end else begin
         if (act_ok_o) begin
            open_q <= 1'b1;
            row_q  <= act_row_i;
            ras_q  <= ras_ld;
         end else if (ras_q != '0) begin
            ras_q <= ras_q - 1'b1;
         end
         if (pre_ok) begin
            open_q <= 1'b0;
            rp_q   <= rp_ld;
         end else if (rp_q != '0) begin
            rp_q <= rp_q - 1'b1;
         end
      end
   end

   assign open_o = open_q;
   assign row_o  = row_q;

   // R2
   open_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(open_q) |-> $past(sel_act_i));
   // R7
   ras_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(open_q) |-> $past(ras_q) == '0);
   // R8
   rp_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(open_q) |-> $past(rp_q) == '0);
   // R5
   row_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_act_i |=> $stable(row_q));

endmodule

// File: rtl/rbt_refresh_ctr.sv
module rbt_refresh_ctr #(
   parameter int ROW_W  = 12,
   parameter int NSLICE = 3,
   localparam int SL_W  = ROW_W / NSLICE,
   localparam int SEL_W = (NSLICE > 1) ? $clog2(NSLICE) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en_i,
   input  logic [SEL_W-1:0] sel_i,
   input  logic [SL_W-1:0]  wdata_i,
   input  logic             inc_i,
   output logic [SL_W-1:0]  rdata_o,
   output logic [ROW_W-1:0] ctr_o
);

   if (ROW_W % NSLICE != 0) begin : g_bad_split
      $error("ROW_W must divide evenly into NSLICE slices");
   end

   logic [ROW_W-1:0]  ctr_q, ctr_d;
   logic [NSLICE-1:0] hit;
   logic              wr_hit;

   for (genvar s = 0; s < NSLICE; s++) begin : g_hit
      assign hit[s] = wr_en_i && (sel_i == SEL_W'(s));
   end
   assign wr_hit = |hit;

   always_comb begin
      ctr_d   = ctr_q;
      rdata_o = '0;
      if (wr_hit) begin
         for (int s = 0; s < NSLICE; s++) begin
            if (hit[s]) ctr_d[s*SL_W +: SL_W] = wdata_i;
         end
      end else if (inc_i) begin
         ctr_d = ctr_q + 1'b1;
      end
      for (int s = 0; s < NSLICE; s++) begin
         if (sel_i == SEL_W'(s)) rdata_o = ctr_q[s*SL_W +: SL_W];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) ctr_q <= '0;
      else        ctr_q <= ctr_d;
   end

   assign ctr_o = ctr_q;

   // R10
   ctr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en_i && !inc_i) |=> $stable(ctr_q));
   // R4
   ctr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && !wr_en_i) |=> ctr_q == $past(ctr_q) + 1'b1);

endmodule

// File: rtl/bank_refresh_tracker.sv
module bank_refresh_tracker
   import rbt_pkg::*;
#(
   parameter int NBANK  = 8,
   parameter int ROW_W  = 12,
   parameter int TIM_W  = 8,
   parameter int NSLICE = 3,
   localparam int BANK_W = $clog2(NBANK),
   localparam int SL_W   = ROW_W / NSLICE,
   localparam int SEL_W  = (NSLICE > 1) ? $clog2(NSLICE) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [2:0]             cmd_op,
   input  logic [BANK_W-1:0]      cmd_bank,
   input  logic [ROW_W-1:0]       cmd_row,
   input  logic [TIM_W-1:0]       cfg_tras,
   input  logic [TIM_W-1:0]       cfg_trp,
   input  logic                   ctr_wr_en,
   input  logic [SEL_W-1:0]       ctr_sel,
   input  logic [SL_W-1:0]        ctr_wdata,
   output logic [SL_W-1:0]        ctr_rdata,
   output logic [NBANK-1:0]       bank_open_o,
   output logic [NBANK*ROW_W-1:0] bank_row_o,
   output logic                   err_state_o,
   output logic                   err_timing_o
);

   if (NBANK < 2 || (1 << BANK_W) != NBANK) begin : g_bad_nbank
      $error("NBANK must be a power of two of at least 2");
   end

   logic [NBANK-1:0] act_vec, pre_vec, v_state, v_time, act_ok;
   logic [ROW_W-1:0] ref_row, act_row;
   logic             inc_req, inc_go;
   logic             err_state_q, err_timing_q;

   rbt_cmd_decode #(.NBANK(NBANK), .ROW_W(ROW_W)) u_dec (
      .op_i      (cmd_op),
      .bank_i    (cmd_bank),
      .pkt_row_i (cmd_row),
      .ref_row_i (ref_row),
      .act_vec_o (act_vec),
      .pre_vec_o (pre_vec),
      .act_row_o (act_row),
      .inc_req_o (inc_req)
   );

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      rbt_bank_slot #(.ROW_W(ROW_W), .TIM_W(TIM_W)) u_slot (
         .clk          (clk),
         .rst_n        (rst_n),
         .sel_act_i    (act_vec[b]),
         .sel_pre_i    (pre_vec[b]),
         .act_row_i    (act_row),
         .tras_i       (cfg_tras),
         .trp_i        (cfg_trp),
         .open_o       (bank_open_o[b]),
         .row_o        (bank_row_o[b*ROW_W +: ROW_W]),
         .viol_state_o (v_state[b]),
         .viol_time_o  (v_time[b]),
         .act_ok_o     (act_ok[b])
      );
   end

   assign inc_go = inc_req && (|act_ok);

   rbt_refresh_ctr #(.ROW_W(ROW_W), .NSLICE(NSLICE)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en_i (ctr_wr_en),
      .sel_i   (ctr_sel),
      .wdata_i (ctr_wdata),
      .inc_i   (inc_go),
      .rdata_o (ctr_rdata),
      .ctr_o   (ref_row)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         err_state_q  <= 1'b0;
         err_timing_q <= 1'b0;
      end else begin
         err_state_q  <= |v_state;
         err_timing_q <= |v_time;
      end
   end

   assign err_state_o  = err_state_q;
   assign err_timing_o = err_timing_q;

   // R6
   state_err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_state_o |-> $past(op_is_act(cmd_op)));
   // R12
   closed_pre_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_is_pre(cmd_op) && !bank_open_o[cmd_bank]) |=> !err_timing_o && !err_state_o);
   // R9
   one_open_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(bank_open_o & ~$past(bank_open_o)) <= 1);

endmodule

// File: tb/bank_refresh_tracker_tb.sv
module bank_refresh_tracker_tb;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [2:0]  cmd_op;
   logic [2:0]  cmd_bank;
   logic [11:0] cmd_row;
   logic [7:0]  cfg_tras, cfg_trp;
   logic        ctr_wr_en;
   logic [1:0]  ctr_sel;
   logic [3:0]  ctr_wdata;
   logic [3:0]  ctr_rdata;
   logic [7:0]  bank_open_o;
   logic [95:0] bank_row_o;
   logic        err_state_o, err_timing_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   always #10 clk = ~clk;

   bank_refresh_tracker u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
      .cmd_row(cmd_row), .cfg_tras(cfg_tras), .cfg_trp(cfg_trp),
      .ctr_wr_en(ctr_wr_en), .ctr_sel(ctr_sel), .ctr_wdata(ctr_wdata),
      .ctr_rdata(ctr_rdata), .bank_open_o(bank_open_o), .bank_row_o(bank_row_o),
      .err_state_o(err_state_o), .err_timing_o(err_timing_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic issue(input logic [2:0] op, input logic [2:0] bank, input logic [11:0] row);
      cmd_op = op; cmd_bank = bank; cmd_row = row;
      @(negedge clk);
      cmd_op = 3'd0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr_slice(input logic [1:0] sel, input logic [3:0] d);
      ctr_wr_en = 1'b1; ctr_sel = sel; ctr_wdata = d;
      @(negedge clk);
      ctr_wr_en = 1'b0;
   endtask

   function automatic logic [11:0] row_of(input int b);
      return bank_row_o[b*12 +: 12];
   endfunction

   task automatic chk_ctr(input string req, input logic [11:0] exp);
      logic [11:0] got;
      for (int s = 0; s < 3; s++) begin
         ctr_sel = 2'(s);
         #1;
         got[s*4 +: 4] = ctr_rdata;
      end
      chk(req, 32'(got), 32'(exp));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; cmd_op = 3'd0; cmd_bank = '0; cmd_row = '0;
      cfg_tras = 8'd4; cfg_trp = 8'd3;
      ctr_wr_en = 1'b0; ctr_sel = 2'd0; ctr_wdata = '0;
      idle(3);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 open", 32'(bank_open_o), 32'h0);
      chk("R1 rows", 32'(|bank_row_o), 32'h0);
      chk("R1 errs", 32'({err_state_o, err_timing_o}), 32'h0);
      chk_ctr("R1 ctr", 12'h000);

      // R2 activate with explicit row
      issue(3'd1, 3'd0, 12'h123);
      chk("R2 open", 32'(bank_open_o[0]), 32'h1);
      chk("R2 row", 32'(row_of(0)), 32'h123);
      chk("R2 err", 32'({err_state_o, err_timing_o}), 32'h0);

      // R10 slice writes and ignored select 3
      wr_slice(2'd0, 4'hA);
      wr_slice(2'd1, 4'hB);
      wr_slice(2'd2, 4'hC);
      chk_ctr("R10 slices", 12'hCBA);
      wr_slice(2'd3, 4'h7);
      chk_ctr("R10 sel3 write ignored", 12'hCBA);
      ctr_sel = 2'd3; #1;
      chk("R10 sel3 read", 32'(ctr_rdata), 32'h0);

      // R3 refresh activate uses counter, no step
      issue(3'd3, 3'd1, 12'h555);
      chk("R3 row", 32'(row_of(1)), 32'hCBA);
      chk_ctr("R3 ctr", 12'hCBA);

      // R4 incrementing refresh and wrap
      issue(3'd4, 3'd2, 12'h555);
      chk("R4 row", 32'(row_of(2)), 32'hCBA);
      chk_ctr("R4 ctr", 12'hCBB);
      wr_slice(2'd0, 4'hF); wr_slice(2'd1, 4'hF); wr_slice(2'd2, 4'hF);
      issue(3'd4, 3'd4, 12'h000);
      chk("R4 wrap row", 32'(row_of(4)), 32'hFFF);
      chk_ctr("R4 wrap ctr", 12'h000);

      // R6 activates to open banks
      issue(3'd3, 3'd1, 12'h0);
      chk("R6 err_state", 32'(err_state_o), 32'h1);
      chk("R6 row kept", 32'(row_of(1)), 32'hCBA);
      issue(3'd4, 3'd2, 12'h0);
      chk("R6 err_state inc", 32'(err_state_o), 32'h1);
      chk_ctr("R6 ctr kept", 12'h000);
      issue(3'd1, 3'd0, 12'h777);
      chk("R6 act row kept", 32'(row_of(0)), 32'h123);

      // R5 both precharge kinds close and keep row
      idle(8);
      issue(3'd2, 3'd0, 12'h0);
      chk("R5 pre closes", 32'(bank_open_o[0]), 32'h0);
      chk("R5 row held", 32'(row_of(0)), 32'h123);
      issue(3'd5, 3'd1, 12'h0);
      chk("R5 rpre closes", 32'(bank_open_o[1]), 32'h0);
      chk("R5 errs", 32'({err_state_o, err_timing_o}), 32'h0);

      // R12 precharge to closed bank is quiet and keeps tRP window
      idle(5);
      issue(3'd2, 3'd0, 12'h0);
      chk("R12 no err", 32'({err_state_o, err_timing_o}), 32'h0);
      issue(3'd1, 3'd0, 12'h321);
      chk("R12 act accepted", 32'(bank_open_o[0]), 32'h1);
      chk("R12 no err after act", 32'(err_timing_o), 32'h0);

      // R11 write wins over increment
      ctr_wr_en = 1'b1; ctr_sel = 2'd2; ctr_wdata = 4'h9;
      issue(3'd4, 3'd5, 12'h0);
      ctr_wr_en = 1'b0;
      chk("R11 row pre-write", 32'(row_of(5)), 32'h000);
      chk_ctr("R11 ctr", 12'h900);

      // R9 per-bank timers: act7 then act6, pre7 at its tRAS
      issue(3'd1, 3'd7, 12'h070);
      issue(3'd1, 3'd6, 12'h060);
      idle(2);
      issue(3'd2, 3'd7, 12'h0);
      chk("R9 bank7 closed", 32'(bank_open_o[7]), 32'h0);
      chk("R9 no err", 32'(err_timing_o), 32'h0);
      issue(3'd2, 3'd6, 12'h0);
      chk("R9 bank6 closed", 32'(bank_open_o[6]), 32'h0);

      // R7 / R8 sweep of window edges on bank 3
      for (int ras = 1; ras <= 5; ras++) begin
         for (int rp = 1; rp <= 4; rp++) begin
            cfg_tras = 8'(ras); cfg_trp = 8'(rp);
            idle(12);
            issue(3'd1, 3'd3, 12'(ras*16 + rp));
            chk("R7 sweep act", 32'({bank_open_o[3], err_timing_o}), 32'h2);
            if (ras >= 2) begin
               idle(ras - 2);
               issue(3'd2, 3'd3, 12'h0);
               chk("R7 early pre", 32'({bank_open_o[3], err_timing_o}), 32'h3);
            end else begin
               idle(ras - 1);
            end
            issue(3'd2, 3'd3, 12'h0);
            chk("R7 on-time pre", 32'({bank_open_o[3], err_timing_o}), 32'h0);
            if (rp >= 2) begin
               idle(rp - 2);
               issue(3'd1, 3'd3, 12'hABC);
               chk("R8 early act", 32'({bank_open_o[3], err_timing_o}), 32'h1);
            end else begin
               idle(rp - 1);
            end
            issue(3'd1, 3'd3, 12'(rp*256 + ras));
            chk("R8 on-time act", 32'({bank_open_o[3], err_timing_o}), 32'h2);
            chk("R8 row", 32'(row_of(3)), 32'(rp*256 + ras));
            idle(ras);
            issue(3'd2, 3'd3, 12'h0);
         end
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule